// File: doc/BRIEF.md
# Block-Boundary Memory Request Splitter

This block takes one remote-memory request, given as a start address, a byte count of up to 496 bytes and a read/write flag, and turns it into a series of smaller memory-side requests. No generated request is longer than 128 bytes, and none runs past a 128-byte address block. If a request did run past a block, the memory would wrap around inside that block and read or write the wrong locations. Each piece ends at the next block boundary or at the end of the remaining bytes, whichever comes first. As a result, a request that starts in the middle of a block produces a short first piece, full-block middle pieces and a short tail.

Requests enter through a valid/ready handshake. Pieces leave through a second valid/ready handshake, each with an address, a length, the type and a flag that marks the final piece of its request. Every address and length must be a multiple of 16 bytes, and byte-masked writes are not supported. A request with a misaligned address, a length that is not a multiple of 16, or a zero length is consumed and produces no pieces. It raises an error flag for one cycle instead.

A small controller sequences the work. **IDLE** waits for a request. **EMIT** presents one piece per cycle until the final piece is taken. **FAULT** lasts one cycle and signals a rejected request. The transitions are:
- IDLE→EMIT on an accepted good request.
- IDLE→FAULT on an accepted bad request.
- EMIT→EMIT on a taken non-final piece, or while the piece is not taken.
- EMIT→IDLE when the final piece is taken.
- FAULT→IDLE always.

Top module: `mreq_splitter`

## Requirements
- R1: After reset, out_valid and err_flag are 0 and in_ready is 1.
- R2: Every emitted out_len is a multiple of 16 and lies between 16 and 128 inclusive.
- R3: For every emitted piece, (out_addr mod 128) + out_len is at most 128, so no piece crosses a 128-byte block.
- R4: The first piece starts at the request address. Each later piece starts where the previous one ended. Each length equals min(remaining bytes, 128 − (out_addr mod 128)), and the lengths add up to the request byte count.
- R5: out_last is 1 on the final piece of a request and 0 on every other piece.
- R6: out_write equals the in_write value of the request (1 = write, 0 = read) on every piece of that request.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_addr, out_len, out_last and out_write hold their values.
- R8: A request is rejected when in_addr[3:0] ≠ 0, when in_bytes[3:0] ≠ 0, or when in_bytes = 0. A rejected request raises err_flag for exactly the one cycle after acceptance, produces no piece (out_valid stays 0), and leaves in_ready high again the cycle after that.
- R9: in_ready is 1 only while no piece is pending. While pieces of a request are being emitted, in_ready is 0.
- R10: The first piece is valid in the cycle after the request is accepted. With out_ready held high, one piece is taken per cycle, and in_ready returns to 1 in the cycle after the final piece is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request descriptor valid |
| in_ready | output | 1 | Splitter can take a request |
| in_addr | input | ADDR_W (32) | Request start byte address |
| in_bytes | input | LEN_W (9) | Request byte count |
| in_write | input | 1 | Request type: 1 write, 0 read |
| out_valid | output | 1 | Piece descriptor valid |
| out_ready | input | 1 | Downstream takes the piece |
| out_addr | output | ADDR_W (32) | Piece start byte address |
| out_len | output | CHUNK_W (8) | Piece length in bytes |
| out_write | output | 1 | Piece type, copied from the request |
| out_last | output | 1 | Final piece of the request |
| err_flag | output | 1 | One-cycle pulse for a rejected request |

## Verification
The splitter is tried with five request shapes. Each shape tells apart a different way of cutting a request:
- A block-aligned 128-byte request must produce a single full piece.
- A 64-byte request that ends exactly on a boundary must not produce an empty extra piece.
- A 496-byte request at offset 16 yields a short head followed by full blocks, with no tail.
- A 496-byte request at offset 112 yields a 16-byte head, three full blocks and a 96-byte tail.
- A 32-byte request just below a boundary has to be split in two, even though it is far smaller than a block.

One long request is drained with a stall before every piece, which separates correct holding from early advance. Three malformed requests exercise each rejection cause on its own. The bench also confirms that a good request is accepted normally after a rejection.

// File: rtl/msplit_pkg.sv
package msplit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_FAULT = 2'd2
    } split_state_e;

endpackage

// File: rtl/msplit_check.sv
module msplit_check #(
    parameter int LEN_W = 9,
    parameter int GRAN  = 16,
    localparam int GRAN_W = (GRAN > 1) ? $clog2(GRAN) : 1
) (
    input  logic [GRAN_W-1:0] addr_lo,
    input  logic [LEN_W-1:0]  bytes,
    output logic              bad
);

    logic misaligned;
    logic empty;

    generate
        if (GRAN > 1) begin : g_gran
            // Both the start and the size must land on the access granule.
            assign misaligned = (addr_lo != '0) || (bytes[GRAN_W-1:0] != '0);
        end else begin : g_byte
            logic unused_lo;
            assign unused_lo  = ^addr_lo;
            assign misaligned = 1'b0;
        end
    endgenerate

    assign empty = (bytes == '0);
    assign bad   = misaligned || empty;

endmodule

// File: rtl/msplit_chunk_calc.sv
module msplit_chunk_calc #(
    parameter int LEN_W     = 9,
    parameter int BLK_BYTES = 128,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int CHUNK_W  = $clog2(BLK_BYTES + 1),
    localparam int CMP_W    = (LEN_W > CHUNK_W) ? LEN_W : CHUNK_W
) (
    input  logic [OFF_W-1:0]   offset,
    input  logic [LEN_W-1:0]   remain,
    output logic [CHUNK_W-1:0] chunk_len,
    output logic               chunk_last
);

    logic [CHUNK_W-1:0] room;
    logic [CMP_W-1:0]   room_x;
    logic [CMP_W-1:0]   remain_x;

    // Bytes left before the current block ends.
    assign room     = CHUNK_W'(BLK_BYTES) - CHUNK_W'(offset);
    assign room_x   = CMP_W'(room);
    assign remain_x = CMP_W'(remain);

    always_comb begin
        if (remain_x <= room_x) begin
            chunk_len  = CHUNK_W'(remain_x);
            chunk_last = 1'b1;
        end else begin
            chunk_len  = room;
            chunk_last = 1'b0;
        end
    end

endmodule

// File: rtl/mreq_splitter.sv
module mreq_splitter
    import msplit_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 496,
    parameter int BLK_BYTES = 128,
    parameter int GRAN      = 16,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int CHUNK_W  = $clog2(BLK_BYTES + 1),
    localparam int GRAN_W   = (GRAN > 1) ? $clog2(GRAN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [LEN_W-1:0]   in_bytes,
    input  logic               in_write,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [CHUNK_W-1:0] out_len,
    output logic               out_write,
    output logic               out_last,
    output logic               err_flag
);

    split_state_e       state_q;
    split_state_e       state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   rem_q;
    logic               wr_q;
    logic               req_bad;
    logic [CHUNK_W-1:0] chunk_len;
    logic               chunk_last;
    logic               take_req;
    logic               take_piece;

    msplit_check #(
        .LEN_W (LEN_W),
        .GRAN  (GRAN)
    ) u_check (
        .addr_lo (in_addr[GRAN_W-1:0]),
        .bytes   (in_bytes),
        .bad     (req_bad)
    );

    msplit_chunk_calc #(
        .LEN_W     (LEN_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_calc (
        .offset     (addr_q[OFF_W-1:0]),
        .remain     (rem_q),
        .chunk_len  (chunk_len),
        .chunk_last (chunk_last)
    );

    // Handshake events.
    assign take_req   = (state_q == ST_IDLE) && in_valid;
    assign take_piece = (state_q == ST_EMIT) && out_ready;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = req_bad ? ST_FAULT : ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready && chunk_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FAULT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Cursor: the next piece address and the bytes still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            wr_q   <= 1'b0;
        end else if (take_req && !req_bad) begin
            addr_q <= in_addr;
            rem_q  <= in_bytes;
            wr_q   <= in_write;
        end else if (take_piece) begin
            addr_q <= addr_q + ADDR_W'(chunk_len);
            rem_q  <= rem_q - LEN_W'(chunk_len);
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        err_flag  = 1'b0;
        unique case (state_q)
            ST_IDLE:  in_ready  = 1'b1;
            ST_EMIT:  out_valid = 1'b1;
            ST_FAULT: err_flag  = 1'b1;
            default:  in_ready  = 1'b0;
        endcase
    end

    assign out_addr  = addr_q;
    assign out_len   = chunk_len;
    assign out_last  = chunk_last;
    assign out_write = wr_q;

endmodule

// File: rtl/msplit_sva.sv
module msplit_sva #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 128,
    parameter int GRAN      = 16,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int CHUNK_W  = $clog2(BLK_BYTES + 1),
    localparam int GRAN_W   = (GRAN > 1) ? $clog2(GRAN) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [CHUNK_W-1:0] out_len,
    input logic               out_write,
    input logic               out_last,
    input logic               err_flag
);

    logic [CHUNK_W:0] end_off;
    assign end_off = (CHUNK_W+1)'(out_addr[OFF_W-1:0]) + (CHUNK_W+1)'(out_len);

    // R2
    a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len != '0) && (out_len <= CHUNK_W'(BLK_BYTES))
                      && (out_len[GRAN_W-1:0] == '0 || GRAN == 1));

    // R3
    a_r3_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> end_off <= (CHUNK_W+1)'(BLK_BYTES));

    // R7
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len)
                                    && $stable(out_last) && $stable(out_write));

    // R8
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !out_valid && !in_ready);

    // R8
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !err_flag && in_ready);

    // R9
    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10
    a_r10_last_release: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> in_ready && !out_valid);

endmodule

bind mreq_splitter msplit_sva #(
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES),
    .GRAN      (GRAN)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_len   (out_len),
    .out_write (out_write),
    .out_last  (out_last),
    .err_flag  (err_flag)
);

// File: tb/mreq_splitter_bench.sv
`timescale 1ns/1ps
module mreq_splitter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [8:0]  in_bytes = '0;
    logic        in_write = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_addr;
    logic [7:0]  out_len;
    logic        out_write;
    logic        out_last;
    logic        err_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mreq_splitter u_mreq_splitter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_addr   (in_addr),
        .in_bytes  (in_bytes),
        .in_write  (in_write),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_addr  (out_addr),
        .out_len   (out_len),
        .out_write (out_write),
        .out_last  (out_last),
        .err_flag  (err_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(err_flag == 1'b0, "R1", "err_flag after reset", err_flag, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    endtask

    // Drives one good request and follows every piece against a model
    // built from R4: length = min(remaining, 128 - addr mod 128).
    task automatic run_split(input logic [31:0] a, input int nbytes, input bit wr,
                             input bit stall);
        logic [31:0] exp_a;
        int          rem;
        int          room;
        int          el;
        int          total;
        logic [31:0] held_a;
        logic [7:0]  held_l;
        exp_a = a;
        rem   = nbytes;
        total = 0;
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready before request", in_ready, 1);
        in_valid = 1'b1;
        in_addr  = a;
        in_bytes = 9'(nbytes);
        in_write = wr;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R10", "first piece one cycle after accept", out_valid, 1);
        while (rem > 0) begin
            room = 128 - int'(exp_a % 128);
            el   = (rem < room) ? rem : room;
            if (stall) begin
                out_ready = 1'b0;
                held_a = out_addr;
                held_l = out_len;
                @(negedge clk);
                check(out_valid && out_addr == held_a && out_len == held_l, "R7",
                      "piece held under stall", out_addr, held_a);
            end
            check(out_valid == 1'b1, "R10", "piece valid", out_valid, 1);
            check(in_ready == 1'b0, "R9", "in_ready while busy", in_ready, 0);
            check(out_addr == exp_a, "R4", "piece address", out_addr, exp_a);
            check(int'(out_len) == el, "R4", "piece length", out_len, el);
            check(out_len >= 16 && out_len <= 128 && out_len % 16 == 0, "R2",
                  "piece length range", out_len, el);
            check(int'(out_addr % 128) + int'(out_len) <= 128, "R3",
                  "block crossing", int'(out_addr % 128) + int'(out_len), 128);
            check(out_last == (el == rem), "R5", "last flag", out_last, (el == rem));
            check(out_write == wr, "R6", "type copied", out_write, wr);
            out_ready = 1'b1;
            @(negedge clk);
            exp_a = exp_a + 32'(el);
            rem   = rem - el;
            total = total + el;
        end
        out_ready = 1'b0;
        check(total == nbytes, "R4", "bytes covered", total, nbytes);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after last piece",
              {out_valid, in_ready}, 2'b01);
    endtask

    task automatic run_reject(input logic [31:0] a, input int nbytes, input string why);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        in_bytes = 9'(nbytes);
        in_write = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(err_flag == 1'b1, "R8", {"err raised: ", why}, err_flag, 1);
        check(out_valid == 1'b0, "R8", {"no piece: ", why}, out_valid, 0);
        @(negedge clk);
        check(err_flag == 1'b0, "R8", {"err one cycle: ", why}, err_flag, 0);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R8", {"back to idle: ", why},
              {out_valid, in_ready}, 2'b01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_split(32'h0000_1000, 128, 1'b1, 1'b0);
        run_split(32'h0000_0040, 64, 1'b0, 1'b0);
        run_split(32'h0000_2010, 496, 1'b1, 1'b0);
        run_split(32'h0000_3070, 496, 1'b0, 1'b1);
        run_split(32'h0000_40F0, 32, 1'b1, 1'b0);
        run_reject(32'h0000_1008, 64, "misaligned address");
        run_reject(32'h0000_1000, 40, "length not multiple of 16");
        run_reject(32'h0000_1000, 0, "zero length");
        run_split(32'h0000_5000, 256, 1'b0, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule